// File: doc/BRIEF.md
# Memory Response Ordering Buffer

This block sits between a pipeline that issues memory requests and the memory side that returns their responses. Every accepted request is given a sequence ID, starting at zero and wrapping modulo 2^SEQ_W. The block then hands completed responses back to the pipeline one at a time through a ready/pop pair. Before issuing, the caller can reserve room for requests it will issue shortly: it passes the number of pending requests with its issue check, and the block grants the issue only if those reservations also fit.

A mode input chooses the retirement order. In sequence mode, a returning response only marks its slot as finished. The pipeline is offered the oldest outstanding request, and only once that request has finished, so a younger finished request waits behind an unfinished older one. In arrival mode, each returning response is copied into one of two response queues, one for loads and one for stores, according to the kind the response carries. The pipeline is offered whichever queued response arrived first. Slots in the tracking table are freed from the oldest end as responses come back. The mode can only switch while the block holds nothing.

Top module: `mem_resp_order`

## Requirements
- R1: While reset is held and just after it is released, rdy_o=0, err_o=0, mode_o=0 (sequence mode), iss_ready_o=1 when iss_pend_i=0, and iss_seq_o=0.
- R2: iss_ready_o is 1 exactly when the outstanding-request count plus iss_pend_i is less than Q. Each accepted issue gets the ID shown on iss_seq_o. IDs follow each other by one and wrap modulo 2^SEQ_W.
- R3: In sequence mode (mode_o=0), rdy_o rises only when the oldest outstanding request has a response. rdy_seq_o then shows that request's ID, and rdy_store_o shows the kind it was issued with (1 = store). Responses to younger requests raise nothing.
- R4: In sequence mode, a pop (pop_i=1 while rdy_o=1) retires the oldest request, frees its slot for issue, and moves the offer to the next ID.
- R5: In arrival mode (mode_o=1), responses are offered in the order they were accepted, across both kinds. rdy_store_o reports the kind the response carried. If a load and a store are equally old, the load goes first.
- R6: ld_wr_rdy_o (st_wr_rdy_o) is 1 exactly while the load (store) queue holds fewer than Q entries. In arrival mode, a response whose queue is full is dropped and raises err_o. Its request stays outstanding and can be answered again later.
- R7: A response whose ID is not outstanding, or whose request already has a response, is dropped and raises err_o on the cycle after it is presented, for one cycle.
- R8: mode_o takes the value of ooo_mode_i (1 = arrival mode) only in cycles when no request is outstanding and both queues are empty. At other times a change on ooo_mode_i is ignored.
- R9: While rdy_o=1 and no pop is made, rdy_o stays 1 and rdy_seq_o stays unchanged.
- R10: In arrival mode, a table slot is freed only once every older request has returned. Slots are freed at one per cycle, so a request that has not returned blocks issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ooo_mode_i | input | 1 | Requested mode: 0 sequence, 1 arrival |
| mode_o | output | 1 | Active mode |
| iss_valid_i | input | 1 | Issue a request |
| iss_store_i | input | 1 | Kind of the issued request (1 = store) |
| iss_pend_i | input | CNT_W | Number of reserved pending requests |
| iss_ready_o | output | 1 | Issue is allowed |
| iss_seq_o | output | SEQ_W | ID the next issued request receives |
| resp_valid_i | input | 1 | Response present |
| resp_seq_i | input | SEQ_W | ID of the response |
| resp_store_i | input | 1 | Kind of the response (1 = store) |
| ld_wr_rdy_o | output | 1 | Load queue has room |
| st_wr_rdy_o | output | 1 | Store queue has room |
| err_o | output | 1 | Previous-cycle response was dropped |
| rdy_o | output | 1 | A response is offered |
| rdy_seq_o | output | SEQ_W | ID of the offered response |
| rdy_store_o | output | 1 | Kind of the offered response |
| pop_i | input | 1 | Consume the offered response |

## Verification
Suppose a finished flag were set on the wrong slot, or the head pointer drifted. The offered ID would then skip or repeat, or rdy_o would rise while the oldest request is still open. This would be visible at the first pop after the fault. A wrong outstanding count shows up in iss_ready_o on the same cycle, when pending-count sweeps run at every occupancy. A wrong arrival stamp or queue pointer puts the pop sequence out of order in arrival mode. A wrong ID range check turns into a missing or spurious err_o one cycle after the response.

// File: rtl/mro_pkg.sv
package mro_pkg;
  typedef enum logic {
    MODE_SEQ = 1'b0,
    MODE_ARR = 1'b1
  } mode_e;

  // a is older than or equal to b under modular stamps
  function automatic logic stamp_le(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d;
    d = b - a;
    return ~d[7];
  endfunction
endpackage

// File: rtl/mro_seq_table.sv
module mro_seq_table #(
  parameter int Q     = 8,
  parameter int SEQ_W = 8,
  localparam int IDX_W = $clog2(Q),
  localparam int CNT_W = $clog2(Q + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             alloc_store_i,
  output logic [SEQ_W-1:0] alloc_seq_o,
  output logic [CNT_W-1:0] cnt_o,
  input  logic             ret_valid_i,
  input  logic [SEQ_W-1:0] ret_seq_i,
  output logic             ret_hit_o,
  input  logic             mark_i,
  input  logic             free_i,
  output logic             head_done_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic             head_store_o
);
  logic [SEQ_W-1:0] head_q, tail_q, off;
  logic [CNT_W-1:0] cnt_q;
  logic [Q-1:0]     done_q, store_q;
  logic [IDX_W-1:0] head_idx, tail_idx, ret_idx;

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign ret_idx  = ret_seq_i[IDX_W-1:0];
  assign off      = ret_seq_i - head_q;

  assign ret_hit_o    = ret_valid_i && (off < SEQ_W'(cnt_q)) && !done_q[ret_idx];
  assign head_done_o  = (cnt_q != '0) && done_q[head_idx];
  assign head_seq_o   = head_q;
  assign head_store_o = store_q[head_idx];
  assign alloc_seq_o  = tail_q;
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      done_q  <= '0;
      store_q <= '0;
    end else begin
      if (alloc_i) begin
        done_q[tail_idx]  <= 1'b0;
        store_q[tail_idx] <= alloc_store_i;
        tail_q            <= tail_q + 1'b1;
      end
      if (mark_i) done_q[ret_idx] <= 1'b1;
      if (free_i) head_q <= head_q + 1'b1;
      case ({alloc_i, free_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mro_resp_fifo.sv
module mro_resp_fifo #(
  parameter int Q     = 8,
  parameter int SEQ_W = 8,
  localparam int IDX_W = $clog2(Q),
  localparam int CNT_W = $clog2(Q + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  input  logic [SEQ_W-1:0] push_stamp_i,
  input  logic             pop_i,
  output logic             empty_o,
  output logic             wr_rdy_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic [SEQ_W-1:0] head_stamp_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [SEQ_W-1:0] seq_mem   [Q];
  logic [SEQ_W-1:0] stamp_mem [Q];
  logic [IDX_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o      = (cnt_q == '0);
  assign wr_rdy_o     = (cnt_q < CNT_W'(Q));
  assign head_seq_o   = seq_mem[rd_q];
  assign head_stamp_o = stamp_mem[rd_q];
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < Q; i++) begin
        seq_mem[i]   <= '0;
        stamp_mem[i] <= '0;
      end
    end else begin
      if (push_i) begin
        seq_mem[wr_q]   <= push_seq_i;
        stamp_mem[wr_q] <= push_stamp_i;
        wr_q            <= wr_q + 1'b1;
      end
      if (pop_i) rd_q <= rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mem_resp_order.sv
module mem_resp_order
  import mro_pkg::*;
#(
  parameter int Q     = 8,
  parameter int SEQ_W = 8,
  localparam int CNT_W = $clog2(Q + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ooo_mode_i,
  output logic             mode_o,
  input  logic             iss_valid_i,
  input  logic             iss_store_i,
  input  logic [CNT_W-1:0] iss_pend_i,
  output logic             iss_ready_o,
  output logic [SEQ_W-1:0] iss_seq_o,
  input  logic             resp_valid_i,
  input  logic [SEQ_W-1:0] resp_seq_i,
  input  logic             resp_store_i,
  output logic             ld_wr_rdy_o,
  output logic             st_wr_rdy_o,
  output logic             err_o,
  output logic             rdy_o,
  output logic [SEQ_W-1:0] rdy_seq_o,
  output logic             rdy_store_o,
  input  logic             pop_i
);
  mode_e            mode_q;
  logic             err_q;
  logic [SEQ_W-1:0] arr_q;
  logic [CNT_W-1:0] tbl_cnt, ld_cnt, st_cnt;
  logic [SEQ_W-1:0] head_seq;
  logic             tbl_hit, head_done, head_store;
  logic             alloc, accept, take, free, all_empty, arr_mode;
  logic             tgt_rdy, pick_ld;

  // index 0 = loads, 1 = stores
  logic [1:0]       f_push, f_pop, f_empty, f_rdy;
  logic [SEQ_W-1:0] f_seq   [2];
  logic [SEQ_W-1:0] f_stamp [2];
  logic [CNT_W-1:0] f_cnt   [2];

  assign arr_mode    = (mode_q == MODE_ARR);
  assign iss_ready_o = ({1'b0, tbl_cnt} + {1'b0, iss_pend_i}) < (CNT_W + 1)'(Q);
  assign alloc       = iss_valid_i && iss_ready_o;

  mro_seq_table #(.Q(Q), .SEQ_W(SEQ_W)) u_tbl (
    .clk_i,
    .rst_ni,
    .alloc_i       (alloc),
    .alloc_store_i (iss_store_i),
    .alloc_seq_o   (iss_seq_o),
    .cnt_o         (tbl_cnt),
    .ret_valid_i   (resp_valid_i),
    .ret_seq_i     (resp_seq_i),
    .ret_hit_o     (tbl_hit),
    .mark_i        (accept),
    .free_i        (free),
    .head_done_o   (head_done),
    .head_seq_o    (head_seq),
    .head_store_o  (head_store)
  );

  assign tgt_rdy = resp_store_i ? f_rdy[1] : f_rdy[0];
  assign accept  = tbl_hit && (!arr_mode || tgt_rdy);

  assign f_push[0] = arr_mode && accept && !resp_store_i;
  assign f_push[1] = arr_mode && accept && resp_store_i;

  for (genvar k = 0; k < 2; k++) begin : g_fifo
    mro_resp_fifo #(.Q(Q), .SEQ_W(SEQ_W)) u_fifo (
      .clk_i,
      .rst_ni,
      .push_i       (f_push[k]),
      .push_seq_i   (resp_seq_i),
      .push_stamp_i (arr_q),
      .pop_i        (f_pop[k]),
      .empty_o      (f_empty[k]),
      .wr_rdy_o     (f_rdy[k]),
      .head_seq_o   (f_seq[k]),
      .head_stamp_o (f_stamp[k]),
      .cnt_o        (f_cnt[k])
    );
  end

  assign ld_cnt      = f_cnt[0];
  assign st_cnt      = f_cnt[1];
  assign ld_wr_rdy_o = f_rdy[0];
  assign st_wr_rdy_o = f_rdy[1];

  assign pick_ld = !f_empty[0] && (f_empty[1] || stamp_le(f_stamp[0], f_stamp[1]));

  always_comb begin
    if (arr_mode) begin
      rdy_o       = !f_empty[0] || !f_empty[1];
      rdy_seq_o   = pick_ld ? f_seq[0] : f_seq[1];
      rdy_store_o = !pick_ld;
    end else begin
      rdy_o       = head_done;
      rdy_seq_o   = head_seq;
      rdy_store_o = head_store;
    end
  end

  assign take     = pop_i && rdy_o;
  assign free     = arr_mode ? head_done : take;
  assign f_pop[0] = arr_mode && take && pick_ld;
  assign f_pop[1] = arr_mode && take && !pick_ld;

  assign all_empty = (tbl_cnt == '0) && f_empty[0] && f_empty[1];
  assign mode_o    = mode_q;
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SEQ;
      err_q  <= 1'b0;
      arr_q  <= '0;
    end else begin
      if (all_empty) mode_q <= mode_e'(ooo_mode_i);
      err_q <= resp_valid_i && !accept;
      if (f_push[0] || f_push[1]) arr_q <= arr_q + 1'b1;
    end
  end
endmodule

// File: rtl/mro_checker.sv
module mro_checker #(
  parameter int Q     = 8,
  parameter int SEQ_W = 8,
  localparam int CNT_W = $clog2(Q + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_o,
  input logic             rdy_o,
  input logic             pop_i,
  input logic [SEQ_W-1:0] rdy_seq_o,
  input logic             resp_valid_i,
  input logic             err_o,
  input logic             tbl_hit,
  input logic [CNT_W-1:0] tbl_cnt,
  input logic [CNT_W-1:0] ld_cnt,
  input logic [CNT_W-1:0] st_cnt,
  input logic             all_empty
);
  a_r9_offer_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && !pop_i |=> rdy_o && (rdy_seq_o == $past(rdy_seq_o)));

  a_r4_next_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o && rdy_o && pop_i |=> !rdy_o || (rdy_seq_o == SEQ_W'($past(rdy_seq_o) + 1'b1)));

  a_r7_miss_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_i && !tbl_hit |=> err_o);

  a_r2_tbl_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_cnt <= CNT_W'(Q));

  a_r6_fifo_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cnt <= CNT_W'(Q)) && (st_cnt <= CNT_W'(Q)));

  a_r8_mode_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(all_empty));
endmodule

bind mem_resp_order mro_checker #(.Q(Q), .SEQ_W(SEQ_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_o       (mode_o),
  .rdy_o        (rdy_o),
  .pop_i        (pop_i),
  .rdy_seq_o    (rdy_seq_o),
  .resp_valid_i (resp_valid_i),
  .err_o        (err_o),
  .tbl_hit      (tbl_hit),
  .tbl_cnt      (tbl_cnt),
  .ld_cnt       (ld_cnt),
  .st_cnt       (st_cnt),
  .all_empty    (all_empty)
);

// File: tb/sim_mem_resp_order.sv
module sim_mem_resp_order;
  localparam int Q     = 8;
  localparam int SEQ_W = 8;
  localparam int CNT_W = $clog2(Q + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ooo_mode = 1'b0, mode;
  logic             iss_valid = 1'b0, iss_store = 1'b0, iss_ready;
  logic [CNT_W-1:0] iss_pend = '0;
  logic [SEQ_W-1:0] iss_seq;
  logic             resp_valid = 1'b0, resp_store = 1'b0;
  logic [SEQ_W-1:0] resp_seq = '0;
  logic             ld_wr_rdy, st_wr_rdy, err, rdy, rdy_store;
  logic [SEQ_W-1:0] rdy_seq;
  logic             pop = 1'b0;

  int total = 0, bad = 0;
  bit fin = 1'b0;
  int nseq = 0;
  int order [8] = '{3, 6, 0, 1, 7, 2, 5, 4};

  always #5 clk = ~clk;

  mem_resp_order #(.Q(Q), .SEQ_W(SEQ_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ooo_mode_i(ooo_mode), .mode_o(mode),
    .iss_valid_i(iss_valid), .iss_store_i(iss_store), .iss_pend_i(iss_pend),
    .iss_ready_o(iss_ready), .iss_seq_o(iss_seq),
    .resp_valid_i(resp_valid), .resp_seq_i(resp_seq), .resp_store_i(resp_store),
    .ld_wr_rdy_o(ld_wr_rdy), .st_wr_rdy_o(st_wr_rdy), .err_o(err),
    .rdy_o(rdy), .rdy_seq_o(rdy_seq), .rdy_store_o(rdy_store), .pop_i(pop)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    iss_valid  = 1'b0;
    resp_valid = 1'b0;
    pop        = 1'b0;
  endtask

  task automatic issue(input bit st);
    iss_valid = 1'b1;
    iss_store = st;
    cyc();
  endtask

  task automatic resp(input int s, input bit st);
    resp_valid = 1'b1;
    resp_seq   = s[SEQ_W-1:0];
    resp_store = st;
    cyc();
  endtask

  task automatic popc();
    pop = 1'b1;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 rdy", rdy, 0);
    chk("R1 err", err, 0);
    chk("R1 mode", mode, 0);
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 iss_seq", iss_seq, 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 rdy after release", rdy, 0);

    // R2 pending sweep at every occupancy
    for (int k = 0; k <= Q; k++) begin
      for (int p = 0; p <= Q; p++) begin
        iss_pend = CNT_W'(p);
        cyc();
        chk($sformatf("R2 ready occ=%0d pend=%0d", k, p), iss_ready, (k + p < Q) ? 1 : 0);
      end
      iss_pend = '0;
      if (k < Q) begin
        chk("R2 issue id", iss_seq, k);
        issue(k[0]);
      end
    end
    nseq = Q;

    // R3 younger responses wait behind the oldest
    for (int k = Q - 1; k >= 1; k--) begin
      resp(k, k[0]);
      chk("R3 no offer while oldest open", rdy, 0);
    end
    resp(0, 1'b0);
    chk("R3 offer", rdy, 1);
    chk("R3 offer id", rdy_seq, 0);
    chk("R3 offer kind", rdy_store, 0);
    cyc();
    chk("R9 held", rdy, 1);
    chk("R9 held id", rdy_seq, 0);
    chk("R4 full before pop", iss_ready, 0);
    popc();
    chk("R4 slot freed", iss_ready, 1);
    for (int k = 1; k < Q; k++) begin
      chk("R4 offer", rdy, 1);
      chk("R4 order id", rdy_seq, k);
      chk("R3 kind", rdy_store, k % 2);
      popc();
    end
    chk("R4 drained", rdy, 0);

    // R7 stale, unknown and duplicate responses
    resp(3, 1'b1);
    chk("R7 stale id", err, 1);
    cyc();
    chk("R7 err one cycle", err, 0);
    resp(200, 1'b0);
    chk("R7 unknown id", err, 1);
    chk("R7 no offer", rdy, 0);
    issue(1'b0);
    resp(nseq, 1'b0);
    chk("R7 first resp ok", err, 0);
    resp(nseq, 1'b0);
    chk("R7 duplicate", err, 1);
    chk("R7 offer kept", rdy_seq, nseq);
    popc();
    nseq++;

    // R2 wrap of the ID
    for (int i = 0; i < 260; i++) begin
      chk("R2 id wrap", iss_seq, nseq % 256);
      issue(i[0]);
      resp(nseq % 256, i[0]);
      chk("R3 offer id sweep", rdy_seq, nseq % 256);
      popc();
      nseq++;
    end

    // R8 mode change ignored while busy
    issue(1'b0);
    ooo_mode = 1'b1;
    repeat (3) cyc();
    chk("R8 ignored busy", mode, 0);
    resp(nseq % 256, 1'b0);
    chk("R8 ignored pending offer", mode, 0);
    popc();
    nseq++;
    cyc();
    chk("R8 taken when empty", mode, 1);

    // R5 / R10 arrival order across kinds
    base = nseq;
    for (int i = 0; i < Q; i++) issue(i[0]);
    resp((base + order[0]) % 256, order[0] % 2 == 1);
    chk("R5 first arrival", rdy_seq, (base + order[0]) % 256);
    chk("R5 first kind", rdy_store, order[0] % 2);
    resp((base + order[1]) % 256, order[1] % 2 == 1);
    chk("R9 newer arrival keeps offer", rdy_seq, (base + order[0]) % 256);
    chk("R10 no slot before oldest", iss_ready, 0);
    for (int j = 2; j < Q; j++) resp((base + order[j]) % 256, order[j] % 2 == 1);
    iss_pend = CNT_W'(Q - 1);
    repeat (5) cyc();
    chk("R10 slots reclaimed", iss_ready, 1);
    iss_pend = '0;
    for (int j = 0; j < Q; j++) begin
      chk("R5 arrival id", rdy_seq, (base + order[j]) % 256);
      chk("R5 arrival kind", rdy_store, order[j] % 2);
      popc();
    end
    chk("R5 drained", rdy, 0);
    nseq += Q;

    // R6 load queue full
    base = nseq;
    for (int i = 0; i < Q; i++) issue(1'b0);
    for (int i = 0; i < Q; i++) begin
      if (i == Q - 1) chk("R6 room before last", ld_wr_rdy, 1);
      resp((base + i) % 256, 1'b0);
    end
    chk("R6 load full", ld_wr_rdy, 0);
    chk("R6 store room", st_wr_rdy, 1);
    repeat (Q + 1) cyc();
    issue(1'b0);
    resp((base + Q) % 256, 1'b0);
    chk("R6 drop on full", err, 1);
    popc();
    chk("R6 room after pop", ld_wr_rdy, 1);
    resp((base + Q) % 256, 1'b0);
    chk("R6 retry accepted", err, 0);
    for (int i = 1; i <= Q; i++) begin
      chk("R6 load order", rdy_seq, (base + i) % 256);
      popc();
    end
    chk("R6 drained", rdy, 0);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule